// File: doc/BRIEF.md
# Valid-Gated ADC Sample Averager

This block takes a burst of readings from an analog-to-digital converter that sits behind an indirect register port on a PHY. It acts as the master on a simple request/acknowledge command port. After a start pulse it first writes a supplied tuning word into the PHY's tuning-control register. It then reads the converter output register over and over. Each word read back carries its own sample-valid flag. The block waits for the first valid word. After that it adds up the 10-bit sample field of valid words until it has 80 of them. It returns the sum times 1000, divided by 80: the per-sample mean with three decimal places.

Each of the two read phases has a budget of attempts. If a phase runs out before it finishes, the run ends with done and error raised together and the result register is left as it was. An exact sequential divider produces the scaled value. A controller above this block sees only start, the tuning word, a one-cycle done pulse, an error flag and a 32-bit result.

The controller uses eight states:
- ST_IDLE: waits for start.
- ST_TUNE: issues the tuning write.
- ST_SEEK: reads until the valid flag appears.
- ST_GATHER: accumulates samples.
- ST_SCALE: launches the divider.
- ST_WAIT_DIV: waits for the quotient.
- ST_REPORT: success pulse.
- ST_FAIL: error pulse.

The transitions are:
- ST_IDLE→ST_TUNE on start.
- ST_TUNE→ST_SEEK on the write acknowledge.
- ST_SEEK→ST_GATHER on a valid word.
- ST_SEEK→ST_FAIL when the seek budget is exceeded.
- ST_GATHER→ST_SCALE on the 80th valid sample.
- ST_GATHER→ST_FAIL when the gather budget is spent.
- ST_SCALE→ST_WAIT_DIV after one cycle.
- ST_WAIT_DIV→ST_REPORT when the divider finishes.
- ST_REPORT→ST_IDLE and ST_FAIL→ST_IDLE after one cycle.

Top module: `adc_sample_avg`

## Requirements
- R1: After reset, done, error and cmd_req are low and result is 0.
- R2: A start seen in ST_IDLE captures tune_value and causes exactly one write command, with cmd_write=1, cmd_addr=0x0009 and cmd_wdata equal to the captured value, before any read. A start while a run is in progress has no effect.
- R3: A command holds cmd_req, cmd_write, cmd_addr and cmd_wdata steady until a clock edge where cmd_ack is high. cmd_req is low in the cycle after that edge. cmd_rdata is taken in the acknowledge cycle.
- R4: Every read uses cmd_addr=0x000A with cmd_write=0. In the seek phase the block reads until a word with bit 10 set arrives. That first valid word's sample is not added to the sum.
- R5: The seek phase tolerates up to 200 words with bit 10 clear. The 201st such word ends the run in failure.
- R6: In the gather phase, bits [9:0] of each word with bit 10 set are added to the sum. Words with bit 10 clear add nothing. Bits [15:11] never affect the sum.
- R7: The gather phase succeeds if its 80th valid word comes within its first 200 reads. Otherwise the run fails right after the 200th read, and no further command is issued.
- R8: On success, result = floor(sum × 1000 / 80) as a 32-bit value. This is exact for every sum from 0 to 80 × 1023.
- R9: done is a single-cycle pulse. On success it is high, with error low, in the 34th cycle after the edge that accepts the 80th valid word.
- R10: On failure, done and error are high together for one cycle. That cycle is the one directly after the edge that accepts the failing response. result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a measurement (accepted in ST_IDLE only) |
| tune_value | input | 16 | Word written to the tuning-control register |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | High with done when an attempt budget ran out |
| result | output | 32 | Scaled mean, updated on successful runs only |
| cmd_req | output | 1 | Command request, held until acknowledged |
| cmd_write | output | 1 | 1 = register write, 0 = register read |
| cmd_addr | output | 16 | PHY register address |
| cmd_wdata | output | 16 | Write data |
| cmd_ack | input | 1 | One-cycle acknowledge from the PHY port |
| cmd_rdata | input | 16 | Read data, valid while cmd_ack is high |

## Verification
The bench's PHY model records the cycle of the clock edge that takes each acknowledge. It then counts cycles from there to the done pulse, so timing is checked exactly rather than loosely. A failure must show done and error at the negative edge straight after the failing acknowledge edge, which is a count of 0. A success must show them 34 cycles after the edge that carries the 80th valid word: one cycle to launch the divider, 32 divide steps, and one cycle to load the result. Read counts and the tuning write are taken from what the model sees on the port, so off-by-one errors in the attempt budgets appear as wrong read totals.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TUNE,
        ST_SEEK,
        ST_GATHER,
        ST_SCALE,
        ST_WAIT_DIV,
        ST_REPORT,
        ST_FAIL
    } avg_state_e;

endpackage

// File: rtl/adc_avg_cmd_port.sv
module adc_avg_cmd_port #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_write,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [DATA_W-1:0] issue_wdata,
    output logic              port_busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              cmd_req,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_ack,
    input  logic [DATA_W-1:0] cmd_rdata
);

    logic              req_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req_q && cmd_ack) begin
            req_q <= 1'b0;
        end else if (!req_q && issue) begin
            req_q   <= 1'b1;
            wr_q    <= issue_write;
            addr_q  <= issue_addr;
            wdata_q <= issue_wdata;
        end
    end

    assign port_busy = req_q;
    assign rsp_valid = req_q & cmd_ack;
    assign rsp_data  = cmd_rdata;
    assign cmd_req   = req_q;
    assign cmd_write = wr_q;
    assign cmd_addr  = addr_q;
    assign cmd_wdata = wdata_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_write) && $stable(cmd_addr) && $stable(cmd_wdata))); // R3
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_ack) |=> !cmd_req); // R3

endmodule

// File: rtl/adc_avg_accum.sv
module adc_avg_accum #(
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned NSAMP    = 80,
    parameter int unsigned SUM_W    = SAMPLE_W + $clog2(NSAMP + 1),
    parameter int unsigned CNT_W    = $clog2(NSAMP + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                add,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SUM_W-1:0]    sum,
    output logic                last_slot
);

    localparam int unsigned MAX_SAMPLE = (1 << SAMPLE_W) - 1;

    logic [SUM_W-1:0] sum_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (add) begin
            sum_q <= sum_q + SUM_W'(sample);
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign sum       = sum_q;
    assign last_slot = (cnt_q == CNT_W'(NSAMP - 1));

    AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sum_q) <= 32'(cnt_q) * 32'(MAX_SAMPLE)); // R8
    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= 32'(NSAMP)); // R7

endmodule

// File: rtl/adc_avg_div.sv
module adc_avg_div #(
    parameter int unsigned N_W = 32,
    parameter int unsigned D_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic [N_W-1:0] quotient,
    output logic           done
);

    localparam int unsigned CNT_W = $clog2(N_W + 1);

    logic [D_W-1:0]   rem_q;
    logic [N_W-1:0]   quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [D_W:0]     shifted;
    logic [D_W:0]     diff;
    logic             fits;

    always_comb begin
        shifted = {rem_q, quo_q[N_W-1]};
        fits    = (shifted >= {1'b0, divisor});
        diff    = shifted - {1'b0, divisor};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                cnt_q  <= CNT_W'(N_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= fits ? diff[D_W-1:0] : shifted[D_W-1:0];
                quo_q <= {quo_q[N_W-2:0], fits};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;
    assign done     = done_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q < divisor)); // R8

endmodule

// File: rtl/adc_sample_avg.sv
module adc_sample_avg
    import adc_avg_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned SAMPLE_W      = 10,
    parameter int unsigned VALID_BIT     = 10,
    parameter int unsigned NSAMP         = 80,
    parameter int unsigned ATTEMPT_LIMIT = 200,
    parameter int unsigned SCALE         = 1000,
    parameter int unsigned RES_W         = 32,
    parameter int unsigned TUNE_ADDR     = 9,
    parameter int unsigned ADC_ADDR      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tune_value,
    output logic              done,
    output logic              error,
    output logic [RES_W-1:0]  result,
    output logic              cmd_req,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_ack,
    input  logic [DATA_W-1:0] cmd_rdata
);

    localparam int unsigned SUM_W = SAMPLE_W + $clog2(NSAMP + 1);
    localparam int unsigned VCNT_W = $clog2(NSAMP + 1);
    localparam int unsigned ATT_W = $clog2(ATTEMPT_LIMIT + 2);
    localparam int unsigned DIV_W = $clog2(NSAMP + 1);

    avg_state_e        state_q, state_d;
    logic [ATT_W-1:0]  att_q, att_d;
    logic [DATA_W-1:0] tune_q;
    logic [RES_W-1:0]  result_q;

    logic              issue, issue_write;
    logic [ADDR_W-1:0] issue_addr;
    logic              port_busy, rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              word_valid;
    logic              unused_rsp;

    logic              acc_clear, acc_add, acc_last;
    logic [SUM_W-1:0]  acc_sum;
    logic              div_start, div_done;
    logic [RES_W-1:0]  dividend, quotient;

    assign word_valid = rsp_data[VALID_BIT];
    assign unused_rsp = ^rsp_data;

    adc_avg_cmd_port #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .issue_write(issue_write),
        .issue_addr (issue_addr),
        .issue_wdata(tune_q),
        .port_busy  (port_busy),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .cmd_req    (cmd_req),
        .cmd_write  (cmd_write),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .cmd_ack    (cmd_ack),
        .cmd_rdata  (cmd_rdata)
    );

    adc_avg_accum #(
        .SAMPLE_W(SAMPLE_W),
        .NSAMP   (NSAMP),
        .SUM_W   (SUM_W),
        .CNT_W   (VCNT_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (acc_clear),
        .add      (acc_add),
        .sample   (rsp_data[SAMPLE_W-1:0]),
        .sum      (acc_sum),
        .last_slot(acc_last)
    );

    assign dividend = RES_W'(acc_sum) * RES_W'(SCALE);

    adc_avg_div #(
        .N_W(RES_W),
        .D_W(DIV_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (div_start),
        .dividend(dividend),
        .divisor (DIV_W'(NSAMP)),
        .quotient(quotient),
        .done    (div_done)
    );

    // next-state and attempt budget
    always_comb begin
        state_d = state_q;
        att_d   = att_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_TUNE;
                    att_d   = '0;
                end
            end
            ST_TUNE: begin
                if (rsp_valid) state_d = ST_SEEK;
            end
            ST_SEEK: begin
                if (rsp_valid) begin
                    if (word_valid) begin
                        state_d = ST_GATHER;
                        att_d   = '0;
                    end else if (att_q == ATT_W'(ATTEMPT_LIMIT)) begin
                        state_d = ST_FAIL;
                    end else begin
                        att_d = att_q + ATT_W'(1);
                    end
                end
            end
            ST_GATHER: begin
                if (rsp_valid) begin
                    if (word_valid && acc_last) begin
                        state_d = ST_SCALE;
                    end else if (att_q == ATT_W'(ATTEMPT_LIMIT - 1)) begin
                        state_d = ST_FAIL;
                    end else begin
                        att_d = att_q + ATT_W'(1);
                    end
                end
            end
            ST_SCALE:    state_d = ST_WAIT_DIV;
            ST_WAIT_DIV: begin
                if (div_done) state_d = ST_REPORT;
            end
            ST_REPORT:   state_d = ST_IDLE;
            ST_FAIL:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            att_q    <= '0;
            tune_q   <= '0;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            att_q   <= att_d;
            if (state_q == ST_IDLE && start) tune_q <= tune_value;
            if (state_q == ST_WAIT_DIV && div_done) result_q <= quotient;
        end
    end

    // outputs
    always_comb begin
        issue       = 1'b0;
        issue_write = 1'b0;
        issue_addr  = ADDR_W'(ADC_ADDR);
        acc_clear   = 1'b0;
        acc_add     = 1'b0;
        div_start   = 1'b0;
        done        = 1'b0;
        error       = 1'b0;
        unique case (state_q)
            ST_IDLE:   acc_clear = start;
            ST_TUNE: begin
                issue       = !port_busy;
                issue_write = 1'b1;
                issue_addr  = ADDR_W'(TUNE_ADDR);
            end
            ST_SEEK:   issue = !port_busy;
            ST_GATHER: begin
                issue   = !port_busy;
                acc_add = rsp_valid && word_valid;
            end
            ST_SCALE:  div_start = 1'b1;
            ST_WAIT_DIV: ;
            ST_REPORT: done = 1'b1;
            ST_FAIL: begin
                done  = 1'b1;
                error = 1'b1;
            end
            default: ;
        endcase
    end

    assign result = result_q;

    AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        32'(att_q) <= 32'(ATTEMPT_LIMIT)); // R5
    AST_TUNE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> ##1 (cmd_req && cmd_write && cmd_addr == ADDR_W'(TUNE_ADDR))); // R2
    AST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_write) |-> (cmd_addr == ADDR_W'(ADC_ADDR))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |=> !cmd_req); // R7
    AST_RESULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $stable(result)); // R10

endmodule

// File: tb/adc_sample_avg_bench.sv
module adc_sample_avg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tune_value = '0;
    logic        done, error;
    logic [31:0] result;
    logic        cmd_req, cmd_write;
    logic [15:0] cmd_addr, cmd_wdata;
    logic        cmd_ack = 1'b0;
    logic [15:0] cmd_rdata = '0;

    always #2 clk = ~clk;

    adc_sample_avg u_adc_sample_avg (
        .clk(clk), .rst_n(rst_n), .start(start), .tune_value(tune_value),
        .done(done), .error(error), .result(result),
        .cmd_req(cmd_req), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    // PHY model configuration and observations
    int lat = 0, wait_cnt = 0;
    int seek_inv = 0, lead_inv = 0, gap_every = 0, base = 0;
    bit allmax = 0;
    int rd_cnt = 0, wr_cnt = 0, bad_addr = 0, ack_cyc = 0;
    logic [15:0] last_wr_addr = '0, last_wr_data = '0;

    // done observation
    bit got_done;
    int got_n;
    bit got_err;
    logic [31:0] got_res;
    longint last_good = 0;

    // expected model
    bit exp_fail;
    int exp_reads;
    longint exp_sum;

    always @(posedge clk) cyc++;

    function automatic logic [15:0] word_for(input int r);
        int g, h;
        if (r < seek_inv) return 16'hFBFF;
        if (r == seek_inv) return 16'h07FF;
        g = r - seek_inv - 1;
        if (g < lead_inv) return 16'hFBFF;
        h = g - lead_inv;
        if (gap_every > 0 && (h % gap_every) == gap_every - 1) return 16'h03A5;
        if (allmax) return 16'hFFFF;
        return 16'hFC00 | 16'((h * 37 + base) % 1024);
    endfunction

    always @(negedge clk) begin
        if (cmd_ack) begin
            cmd_ack = 1'b0;
            wait_cnt = 0;
        end else if (cmd_req) begin
            if (wait_cnt < lat) wait_cnt++;
            else begin
                wait_cnt = 0;
                cmd_ack = 1'b1;
                ack_cyc = cyc + 1;
                if (cmd_write) begin
                    wr_cnt++;
                    last_wr_addr = cmd_addr;
                    last_wr_data = cmd_wdata;
                end else begin
                    if (cmd_addr != 16'h000A) bad_addr++;
                    cmd_rdata = word_for(rd_cnt);
                    rd_cnt++;
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compute_expect();
        int r = 0, inv = 0, cnt = 0, v = 0;
        logic [15:0] w;
        exp_fail = 0; exp_sum = 0;
        forever begin
            w = word_for(r); r++;
            if (w[10]) break;
            inv++;
            if (inv > 200) begin exp_fail = 1; exp_reads = r; return; end
        end
        forever begin
            w = word_for(r); r++; cnt++;
            if (w[10]) begin exp_sum += longint'(w[9:0]); v++; end
            if (v == 80) begin exp_reads = r; return; end
            if (cnt == 200) begin exp_fail = 1; exp_reads = r; return; end
        end
    endtask

    task automatic launch(input logic [15:0] v);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; bad_addr = 0;
        start = 1'b1; tune_value = v;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        got_done = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done) begin
                got_done = 1; got_n = cyc - ack_cyc; got_err = error; got_res = result;
                break;
            end
        end
        chk("R9", "done seen", got_done, 1);
        @(negedge clk);
        chk("R9", "done one cycle only", done, 0);
    endtask

    task automatic judge(input string tag);
        int rd_before;
        compute_expect();
        chk(tag, "read count", rd_cnt, exp_reads);
        chk("R4", "read address errors", bad_addr, 0);
        chk(exp_fail ? "R10" : "R9", "error flag", got_err, exp_fail);
        if (exp_fail) begin
            chk("R10", "fail latency", got_n, 0);
            chk("R10", "result kept", got_res, last_good);
            rd_before = rd_cnt;
            repeat (5) @(negedge clk);
            chk("R7", "no command after fail", rd_cnt + int'(cmd_req), rd_before);
        end else begin
            chk("R9", "success latency", got_n, 34);
            chk("R8", "result", got_res, (exp_sum * 1000) / 80);
            last_good = got_res;
        end
    endtask

    task automatic set_cfg(input int l, input int si, input int li, input int ge, input int b, input bit am);
        lat = l; seek_inv = si; lead_inv = li; gap_every = ge; base = b; allmax = am;
    endtask

    task automatic t_reset();
        chk("R1", "done", done, 0);
        chk("R1", "error", error, 0);
        chk("R1", "cmd_req", cmd_req, 0);
        chk("R1", "result", result, 0);
    endtask

    task automatic t_basic();
        set_cfg(0, 0, 0, 0, 5, 0);
        launch(16'hA5C3); wait_done();
        chk("R2", "write count", wr_cnt, 1);
        chk("R2", "write address", last_wr_addr, 16'h0009);
        chk("R2", "write data", last_wr_data, 16'hA5C3);
        judge("R4");
    endtask

    task automatic t_max();
        set_cfg(2, 3, 0, 0, 0, 1);
        launch(16'h0001); wait_done();
        judge("R6");
        chk("R8", "full-scale result", got_res, 1023000);
    endtask

    task automatic t_gaps();
        set_cfg(1, 2, 0, 3, 11, 0);
        launch(16'h3C3C); wait_done();
        judge("R6");
    endtask

    task automatic t_seek_edge();
        set_cfg(0, 200, 0, 0, 3, 0);
        launch(16'h0101); wait_done();
        judge("R5");
    endtask

    task automatic t_seek_fail();
        set_cfg(0, 1000, 0, 0, 0, 0);
        launch(16'h0202); wait_done();
        judge("R5");
    endtask

    task automatic t_gather_edge();
        set_cfg(0, 0, 120, 0, 9, 0);
        launch(16'h0303); wait_done();
        judge("R7");
    endtask

    task automatic t_gather_fail();
        set_cfg(0, 0, 121, 0, 9, 0);
        launch(16'h0404); wait_done();
        judge("R7");
    endtask

    task automatic t_busy_start();
        set_cfg(1, 1, 0, 0, 21, 0);
        launch(16'h1111);
        repeat (12) @(negedge clk);
        start = 1'b1; tune_value = 16'h2222;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R2", "busy start ignored: writes", wr_cnt, 1);
        chk("R2", "busy start ignored: data", last_wr_data, 16'h1111);
        judge("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_max();
        t_gaps();
        t_seek_edge();
        t_seek_fail();
        t_gather_edge();
        t_gather_fail();
        t_busy_start();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule